// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block collects interrupt requests from up to fifteen peripherals and drives one interrupt line to the processor. It is built from two identical eight-input stages. The secondary stage's interrupt output is one input of the primary stage, at primary input 2. When the processor acknowledges, the block returns an 8-bit vector that names the handler for the winning request. Each stage has a programmable 5-bit vector base, and the 3-bit index of the winning input completes the vector.

Each stage holds three registers: one latches the request inputs, one masks them, and one records which inputs are in service. Service nests. A request outranks what is in service only when its input index is lower than every index in service. Requests of equal or lower priority wait until the processor strobes end-of-interrupt, and that strobe clears the highest-priority in-service bit. The system request input on line 2 cannot reach primary input 2, because the secondary stage uses that input. It is therefore merged into secondary input 1 and is served as system line 9.

Top module: `cic_cascade`

## Requirements
- R1: After reset, cpu_int and vec_valid are low, nothing is in service, both masks are clear, the primary base is 5'h01 and the secondary base is 5'h0E.
- R2: An unmasked request held on a primary system line (0, 1, 3..7) with nothing in service drives cpu_int high within two clock cycles.
- R3: A one-cycle cpu_ack causes vec_valid to be high for exactly the next cycle. vec_out then holds {base[4:0], index[2:0]}. For system lines 0..7 the primary base and the line number are used. For system lines 8..15 the secondary base and the line number minus 8 are used.
- R4: Within a stage a lower input index has higher priority. All secondary lines together rank at primary input 2, so they sit below system lines 0 and 1 and above lines 3..7.
- R5: A secondary request reaches cpu_int through primary input 2. Its acknowledge sets in-service bits in both stages. A request on system line 2 is served exactly like system line 9, with vector {secondary base, 3'd1}.
- R6: A set mask bit stops that input from raising cpu_int or winning. Setting primary mask bit 2 blocks every secondary line.
- R7: While an input is in service, a request on a lower-index input of the same stage raises cpu_int. Requests on that input or higher-index inputs leave cpu_int low.
- R8: An eoi_pri or eoi_sec strobe clears only the highest-priority in-service bit of its stage. In-service bits change only on acknowledge or end-of-interrupt.
- R9: An acknowledge with no winning request returns {base, 3'b111} of the stage that had no winner and changes no in-service bit.
- R10: A cfg_we cycle writes cfg_mask and cfg_base into the primary stage when cfg_sel is 0 and into the secondary stage when cfg_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 16 | System request lines, active high level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Stage select for the write, 0 primary and 1 secondary |
| cfg_mask | input | 8 | Mask value, one bit per stage input |
| cfg_base | input | 5 | Vector base value |
| cpu_int | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector returned after an acknowledge |
| vec_valid | output | 1 | vec_out is valid this cycle |
| eoi_pri | input | 1 | End-of-interrupt strobe to the primary stage |
| eoi_sec | input | 1 | End-of-interrupt strobe to the secondary stage |

## Verification
The assertions assume that cpu_ack, eoi_pri and eoi_sec are single-cycle strobes. They also assume that the processor never sends an end-of-interrupt to a stage in the same cycle as an acknowledge, since the in-service counts they check would then move by an ambiguous amount. The stimulus keeps to this rule: each strobe is issued from its own task with idle cycles on both sides. Request lines change only at the falling edge and are held for several cycles before they are checked or acknowledged, so the two-register path through the cascade has settled first.

// File: rtl/cic_pkg.sv
// Package cic_pkg
// Types shared by the cascaded interrupt controller and its checker.
// Assumes nothing beyond the standard language.
package cic_pkg;

    // Selects which stage a configuration write targets.
    typedef enum logic {
        STAGE_PRI = 1'b0,
        STAGE_SEC = 1'b1
    } stage_sel_e;

endpackage

// File: rtl/cic_prio_pick.sv
// Module cic_prio_pick
// Finds the lowest set bit of a request vector, which is the highest priority.
// Returns a found flag, the bit's index and a one-hot grant.
// Assumes N is at least 2. The logic is purely combinational.
module cic_prio_pick #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    // Scan from index 0 upward and keep only the first set bit.
    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !seen) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
            seen = seen | req[i];
        end
    end

    // Any request at all means a winner exists.
    assign found = |req;

endmodule

// File: rtl/cic_stage.sv
// Module cic_stage
// One eight-input controller stage. It holds the request, mask, in-service
// and vector base registers. It raises int_out while an unmasked request
// outranks every bit in service. On ack the winner moves into service.
// On eoi the highest-priority in-service bit is cleared.
// Assumes ack and eoi are single-cycle strobes. Reset is synchronous and
// active low.
module cic_stage #(
    parameter int           LINES    = 8,
    parameter int           BASE_W   = 5,
    parameter logic [BASE_W-1:0] BASE_RST = '0,
    localparam int          IDX_W    = $clog2(LINES),
    localparam int          VEC_W    = BASE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  req_in,
    input  logic              cfg_we,
    input  logic [LINES-1:0]  cfg_mask,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              ack,
    input  logic              eoi,
    output logic              int_out,
    output logic [IDX_W-1:0]  win_idx,
    output logic [VEC_W-1:0]  vec,
    output logic [LINES-1:0]  isr_state,
    output logic [LINES-1:0]  mask_state
);

    logic [LINES-1:0]  irr_q;
    logic [LINES-1:0]  imr_q;
    logic [LINES-1:0]  isr_q;
    logic [BASE_W-1:0] base_q;

    logic              isr_found;
    logic [IDX_W-1:0]  isr_idx;
    logic [LINES-1:0]  isr_grant;

    logic [LINES-1:0]  pending;
    logic [LINES-1:0]  eligible;
    logic              win_found;
    logic [LINES-1:0]  win_grant;
    logic [LINES-1:0]  isr_next;

    // Latch the request inputs every cycle (level requests).
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= req_in;
    end

    // Hold the mask and vector base, and load both on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q  <= '0;
            base_q <= BASE_RST;
        end else if (cfg_we) begin
            imr_q  <= cfg_mask;
            base_q <= cfg_base;
        end
    end

    // Find the highest-priority bit currently in service.
    cic_prio_pick #(.N(LINES)) u_isr_pick (
        .req   (isr_q),
        .found (isr_found),
        .idx   (isr_idx),
        .grant (isr_grant)
    );

    // Keep unmasked requests that rank above everything in service.
    always_comb begin
        pending = irr_q & ~imr_q;
        for (int i = 0; i < LINES; i++) begin
            eligible[i] = pending[i] && (!isr_found || (IDX_W'(i) < isr_idx));
        end
    end

    // Choose the most urgent eligible request.
    cic_prio_pick #(.N(LINES)) u_req_pick (
        .req   (eligible),
        .found (win_found),
        .idx   (win_idx),
        .grant (win_grant)
    );

    // Form the vector, using index all-ones when there is no winner.
    always_comb begin
        if (win_found) vec = {base_q, win_idx};
        else           vec = {base_q, {IDX_W{1'b1}}};
    end

    // Next in-service value: eoi clears the top bit, ack adds the winner.
    always_comb begin
        isr_next = isr_q;
        if (eoi)              isr_next = isr_next & ~isr_grant;
        if (ack && win_found) isr_next = isr_next | win_grant;
    end

    // Register the in-service state.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_next;
    end

    assign int_out    = win_found;
    assign isr_state  = isr_q;
    assign mask_state = imr_q;

endmodule

// File: rtl/cic_vec_reg.sv
// Module cic_vec_reg
// Captures the vector on an acknowledge. The secondary stage's vector is
// used when the primary winner is the link input, and the primary stage's
// vector otherwise. valid is high for the one cycle after the acknowledge.
// Assumes ack is a single-cycle strobe. Reset is synchronous and active low.
module cic_vec_reg #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             use_sec,
    input  logic [VEC_W-1:0] pri_vec,
    input  logic [VEC_W-1:0] sec_vec,
    output logic [VEC_W-1:0] vec_out,
    output logic             valid
);

    // Capture the chosen stage's vector on acknowledge and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= ack;
            if (ack) vec_out <= use_sec ? sec_vec : pri_vec;
        end
    end

endmodule

// File: rtl/cic_cascade.sv
// Module cic_cascade
// Top level: two cic_stage instances chained. The secondary interrupt output
// drives primary input LINK_IN. The legacy system line LEGACY_LINE is merged
// into secondary input REDIRECT_IN. Vectors are registered by cic_vec_reg.
// Assumes single-cycle cpu_ack, eoi_pri and eoi_sec strobes. Reset is
// synchronous and active low.
module cic_cascade
    import cic_pkg::*;
#(
    parameter int          LINES        = 8,
    parameter int          BASE_W       = 5,
    parameter int          LINK_IN      = 2,
    parameter int          LEGACY_LINE  = 2,
    parameter int          REDIRECT_IN  = 1,
    parameter logic [BASE_W-1:0] PRI_BASE_RST = 5'h01,
    parameter logic [BASE_W-1:0] SEC_BASE_RST = 5'h0E,
    localparam int         IDX_W        = $clog2(LINES),
    localparam int         VEC_W        = BASE_W + IDX_W,
    localparam int         SYS_LINES    = 2 * LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SYS_LINES-1:0] irq_in,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [LINES-1:0]     cfg_mask,
    input  logic [BASE_W-1:0]    cfg_base,
    output logic                 cpu_int,
    input  logic                 cpu_ack,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 vec_valid,
    input  logic                 eoi_pri,
    input  logic                 eoi_sec
);

    logic [LINES-1:0] pri_req;
    logic [LINES-1:0] sec_req;
    logic             pri_int;
    logic             sec_int;
    logic [IDX_W-1:0] pri_win_idx;
    logic [IDX_W-1:0] sec_win_idx;
    logic [VEC_W-1:0] pri_vec;
    logic [VEC_W-1:0] sec_vec;
    logic [LINES-1:0] pri_isr;
    logic [LINES-1:0] sec_isr;
    logic [LINES-1:0] pri_mask;
    logic [LINES-1:0] sec_mask;
    logic             pri_cfg_we;
    logic             sec_cfg_we;
    logic             link_won;
    logic             sec_ack;

    // Connect the request inputs of each stage, including the link and the redirect.
    for (genvar g = 0; g < LINES; g++) begin : g_wire
        if (g == LINK_IN) begin : g_link
            assign pri_req[g] = sec_int;
        end else begin : g_pri
            assign pri_req[g] = irq_in[g];
        end
        if (g == REDIRECT_IN) begin : g_redir
            assign sec_req[g] = irq_in[LINES + g] | irq_in[LEGACY_LINE];
        end else begin : g_sec
            assign sec_req[g] = irq_in[LINES + g];
        end
    end

    // Send each configuration write to the selected stage.
    assign pri_cfg_we = cfg_we && (stage_sel_e'(cfg_sel) == STAGE_PRI);
    assign sec_cfg_we = cfg_we && (stage_sel_e'(cfg_sel) == STAGE_SEC);

    // Pass the acknowledge to the secondary stage only when the link input wins.
    assign link_won = pri_int && (pri_win_idx == IDX_W'(LINK_IN));
    assign sec_ack  = cpu_ack && link_won;

    cic_stage #(
        .LINES    (LINES),
        .BASE_W   (BASE_W),
        .BASE_RST (PRI_BASE_RST)
    ) u_pri (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (pri_req),
        .cfg_we     (pri_cfg_we),
        .cfg_mask   (cfg_mask),
        .cfg_base   (cfg_base),
        .ack        (cpu_ack),
        .eoi        (eoi_pri),
        .int_out    (pri_int),
        .win_idx    (pri_win_idx),
        .vec        (pri_vec),
        .isr_state  (pri_isr),
        .mask_state (pri_mask)
    );

    cic_stage #(
        .LINES    (LINES),
        .BASE_W   (BASE_W),
        .BASE_RST (SEC_BASE_RST)
    ) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (sec_req),
        .cfg_we     (sec_cfg_we),
        .cfg_mask   (cfg_mask),
        .cfg_base   (cfg_base),
        .ack        (sec_ack),
        .eoi        (eoi_sec),
        .int_out    (sec_int),
        .win_idx    (sec_win_idx),
        .vec        (sec_vec),
        .isr_state  (sec_isr),
        .mask_state (sec_mask)
    );

    cic_vec_reg #(.VEC_W(VEC_W)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (cpu_ack),
        .use_sec (link_won),
        .pri_vec (pri_vec),
        .sec_vec (sec_vec),
        .vec_out (vec_out),
        .valid   (vec_valid)
    );

    assign cpu_int = pri_int;

endmodule

// File: rtl/cic_checker.sv
// Module cic_checker
// Assertions for cic_cascade. It is attached through the bind below and
// observes the top ports, the stage states and the cascade link.
// Assumes single-cycle strobes. Every property is disabled during reset.
module cic_checker #(
    parameter int LINES   = 8,
    parameter int LINK_IN = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ack,
    input logic             cpu_int,
    input logic             vec_valid,
    input logic             eoi_pri,
    input logic             eoi_sec,
    input logic [LINES-1:0] pri_isr,
    input logic [LINES-1:0] sec_isr,
    input logic [LINES-1:0] sec_mask,
    input logic             sec_int,
    input logic             sec_ack
);

    // An acknowledge is followed by one valid vector cycle.
    assert_vec_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> vec_valid);

    // With no acknowledge, the next cycle carries no valid vector.
    assert_vec_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |=> !vec_valid);

    // An acknowledged real request adds exactly one primary in-service bit.
    assert_ack_nests_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_int && !eoi_pri) |=>
        ($countones(pri_isr) == $countones($past(pri_isr)) + 1));

    // An end-of-interrupt removes exactly one primary in-service bit.
    assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pri && (pri_isr != '0) && !cpu_ack) |=>
        ($countones(pri_isr) + 1 == $countones($past(pri_isr))));

    // Primary in-service bits change only on acknowledge or end-of-interrupt.
    assert_isr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoi_pri && !cpu_ack) |=> $stable(pri_isr));

    // Secondary in-service bits change only on its acknowledge or end-of-interrupt.
    assert_sec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoi_sec && !sec_ack) |=> $stable(sec_isr));

    // A fully masked secondary stage never requests the link.
    assert_sec_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&sec_mask) |-> !sec_int);

    // A cascade acknowledge puts the link input and a secondary bit in service.
    assert_cascade_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_ack && !eoi_sec) |=> (pri_isr[LINK_IN] && (sec_isr != '0)));

endmodule

bind cic_cascade cic_checker #(.LINES(LINES), .LINK_IN(LINK_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ack   (cpu_ack),
    .cpu_int   (cpu_int),
    .vec_valid (vec_valid),
    .eoi_pri   (eoi_pri),
    .eoi_sec   (eoi_sec),
    .pri_isr   (pri_isr),
    .sec_isr   (sec_isr),
    .sec_mask  (sec_mask),
    .sec_int   (sec_int),
    .sec_ack   (sec_ack)
);

// File: tb/test_cic_cascade.sv
// Bench test_cic_cascade
// Directed scenarios, one task each. Inputs are driven at the falling edge
// and outputs are sampled at the falling edge.
module test_cic_cascade;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_mask = '0;
    logic [4:0]  cfg_base = '0;
    logic        cpu_int;
    logic        cpu_ack = 1'b0;
    logic [7:0]  vec_out;
    logic        vec_valid;
    logic        eoi_pri = 1'b0;
    logic        eoi_sec = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    cic_cascade i_cic_cascade (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_mask  (cfg_mask),
        .cfg_base  (cfg_base),
        .cpu_int   (cpu_int),
        .cpu_ack   (cpu_ack),
        .vec_out   (vec_out),
        .vec_valid (vec_valid),
        .eoi_pri   (eoi_pri),
        .eoi_sec   (eoi_sec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Acknowledge, then check the vector and the one-cycle valid pulse (R3).
    task automatic do_ack(input logic [7:0] exp_vec, input string tag);
        cpu_ack = 1'b1;
        tick(1);
        cpu_ack = 1'b0;
        chk({tag, " R3 valid"}, vec_valid, 1);
        chk({tag, " vector"}, vec_out, exp_vec);
        tick(1);
        chk({tag, " R3 valid drop"}, vec_valid, 0);
    endtask

    task automatic do_eoi(input bit p, input bit s);
        eoi_pri = p;
        eoi_sec = s;
        tick(1);
        eoi_pri = 1'b0;
        eoi_sec = 1'b0;
        tick(1);
    endtask

    task automatic do_cfg(input bit sel, input logic [7:0] m, input logic [4:0] b);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_mask = m;
        cfg_base = b;
        tick(1);
        cfg_we = 1'b0;
    endtask

    // R1: state after reset.
    task automatic t_reset;
        chk("R1 cpu_int", cpu_int, 0);
        chk("R1 vec_valid", vec_valid, 0);
    endtask

    // R2 and R3: a single primary line.
    task automatic t_single;
        irq_in[5] = 1'b1;
        tick(3);
        chk("R2 int raised", cpu_int, 1);
        do_ack(8'h0D, "R3 line5");
        chk("R7 own line blocked", cpu_int, 0);
        irq_in[5] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        chk("R8 idle after eoi", cpu_int, 0);
    endtask

    // R4: ordering inside a stage and across the cascade.
    task automatic t_priority;
        irq_in[6] = 1'b1;
        irq_in[3] = 1'b1;
        tick(3);
        do_ack(8'h0B, "R4 3 over 6");
        irq_in[3] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        chk("R4 line6 pending", cpu_int, 1);
        do_ack(8'h0E, "R4 line6");
        irq_in[6] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        irq_in[12] = 1'b1;
        irq_in[3] = 1'b1;
        tick(4);
        do_ack(8'h74, "R4 secondary over 3");
        chk("R7 line3 waits behind link", cpu_int, 0);
        irq_in[12] = 1'b0;
        tick(2);
        do_eoi(1, 1);
        tick(2);
        chk("R8 line3 returns", cpu_int, 1);
        do_ack(8'h0B, "R4 line3 after");
        irq_in[3] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        irq_in[13] = 1'b1;
        irq_in[9] = 1'b1;
        tick(4);
        do_ack(8'h71, "R4 9 over 13");
        irq_in[13] = 1'b0;
        irq_in[9] = 1'b0;
        tick(2);
        do_eoi(1, 1);
        tick(2);
        chk("R4 idle", cpu_int, 0);
    endtask

    // R5: the legacy line 2 is served as line 9.
    task automatic t_legacy;
        irq_in[2] = 1'b1;
        tick(4);
        chk("R5 line2 int", cpu_int, 1);
        do_ack(8'h71, "R5 line2 vector");
        chk("R5 int low in service", cpu_int, 0);
        irq_in[2] = 1'b0;
        tick(2);
        do_eoi(1, 1);
        tick(2);
        chk("R5 idle", cpu_int, 0);
    endtask

    // R6: masking a primary line, the link input and a secondary line.
    task automatic t_mask;
        do_cfg(0, 8'h10, 5'h01);
        irq_in[4] = 1'b1;
        tick(3);
        chk("R6 masked line4", cpu_int, 0);
        do_cfg(0, 8'h00, 5'h01);
        chk("R6 unmasked line4", cpu_int, 1);
        do_ack(8'h0C, "R6 line4");
        irq_in[4] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        do_cfg(0, 8'h04, 5'h01);
        irq_in[10] = 1'b1;
        tick(4);
        chk("R6 link masked", cpu_int, 0);
        do_cfg(0, 8'h00, 5'h01);
        chk("R6 link unmasked", cpu_int, 1);
        do_ack(8'h72, "R6 line10");
        irq_in[10] = 1'b0;
        tick(2);
        do_eoi(1, 1);
        do_cfg(1, 8'h40, 5'h0E);
        irq_in[14] = 1'b1;
        tick(4);
        chk("R6 secondary masked", cpu_int, 0);
        do_cfg(1, 8'h00, 5'h0E);
        tick(2);
        chk("R6 secondary unmasked", cpu_int, 1);
        do_ack(8'h76, "R6 line14");
        irq_in[14] = 1'b0;
        tick(2);
        do_eoi(1, 1);
    endtask

    // R7 and R8: nested service and the order in which end-of-interrupt clears.
    task automatic t_nesting;
        irq_in[5] = 1'b1;
        tick(3);
        do_ack(8'h0D, "R7 outer");
        irq_in[6] = 1'b1;
        tick(3);
        chk("R7 lower priority waits", cpu_int, 0);
        irq_in[1] = 1'b1;
        tick(3);
        chk("R7 higher preempts", cpu_int, 1);
        do_ack(8'h09, "R7 inner");
        irq_in[1] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        chk("R8 outer still in service", cpu_int, 0);
        irq_in[5] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        chk("R8 outer cleared", cpu_int, 1);
        do_ack(8'h0E, "R8 line6 after");
        irq_in[6] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        chk("R8 all clear", cpu_int, 0);
    endtask

    // R9: an acknowledge with nothing pending.
    task automatic t_spurious;
        do_ack(8'h0F, "R9 spurious");
        chk("R9 no int", cpu_int, 0);
        irq_in[7] = 1'b1;
        tick(3);
        chk("R9 nothing put in service", cpu_int, 1);
        do_ack(8'h0F, "R9 line7");
        irq_in[7] = 1'b0;
        tick(2);
        do_eoi(1, 0);
    endtask

    // R10: writing the vector bases.
    task automatic t_config;
        do_cfg(0, 8'h00, 5'h10);
        irq_in[0] = 1'b1;
        tick(3);
        do_ack(8'h80, "R10 primary base");
        irq_in[0] = 1'b0;
        tick(2);
        do_eoi(1, 0);
        do_cfg(1, 8'h00, 5'h03);
        irq_in[15] = 1'b1;
        tick(4);
        do_ack(8'h1F, "R10 secondary base");
        irq_in[15] = 1'b0;
        tick(2);
        do_eoi(1, 1);
        do_cfg(0, 8'h00, 5'h01);
        do_cfg(1, 8'h00, 5'h0E);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_single();
        t_priority();
        t_legacy();
        t_mask();
        t_nesting();
        t_spurious();
        t_config();
        tick(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule